// File: doc/BRIEF.md
# Impulse Radio Spreading Transmitter Sequencer

This block turns a packet of raw data bits into a timed sequence of pulse polarities for an impulse-radio pulse generator. A clock-cycle counter divides time into pulse repetition periods. At the first cycle of each period the block raises a one-cycle fire strobe and presents the polarity of the chip to send. Each symbol lasts eleven periods and carries one Barker-spread bit.

A packet begins when `start_i` is seen while the block is idle. First come a programmable number of acquisition symbols, each the plain code. Then payload symbols follow, one for each bit taken through a valid/ready handshake. A bit is only taken at a symbol boundary. If the source has no bit ready at that boundary, the packet ends. Analog shaping, antenna drive and error coding are left to neighbouring logic.

Top module: `ir_spread_tx`

## Requirements
- R1: After reset `busy_o`, `fire_o` and `bit_ready_o` are low.
- R2: A start seen while idle with a nonzero preamble count raises `busy_o` on the next cycle. `fire_o` is high in that same first busy cycle.
- R3: While busy, `fire_o` is high for one cycle at the start of every period of `PRP_CYCLES` clock cycles, and never otherwise.
- R4: The chips of a symbol follow the 11-chip code 1,1,1,0,0,0,1,0,0,1,0, first chip first. `chip_o`=1 asks for a positive pulse and `chip_o`=0 for an inverted pulse.
- R5: The packet opens with `pre_len_i` acquisition symbols. Each of them is the code with no modulation, and no payload bit is taken during them.
- R6: A payload bit of 0 sends the code unchanged. A payload bit of 1 inverts all eleven chips of its symbol.
- R7: `bit_ready_o` rises only in the last clock cycle of a symbol, and only when that symbol is the final acquisition symbol or a payload symbol. A bit is taken when `bit_ready_o` and `bit_valid_i` are both high. After a bit is taken, the next cycle fires a new symbol.
- R8: If no bit is valid at a boundary where one is requested, the packet ends and `busy_o` falls on the next cycle. `busy_o` is therefore high for exactly 11·`PRP_CYCLES` cycles per symbol sent.
- R9: A start seen while busy has no effect on the packet in progress.
- R10: With `pre_len_i`=0, a start raises `bit_ready_o` in the same cycle. The packet opens directly with that payload bit if it is valid. If it is not valid, nothing starts and `busy_o` stays low.
- R11: While busy, `chip_o` changes only in a cycle where `fire_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Packet start request |
| pre_len_i | input | PRE_W | Number of acquisition symbols, sampled at start |
| bit_i | input | 1 | Payload bit |
| bit_valid_i | input | 1 | Payload bit is valid |
| bit_ready_o | output | 1 | Payload bit is taken this cycle if valid |
| fire_o | output | 1 | One-cycle strobe that emits a pulse |
| chip_o | output | 1 | Polarity of the current pulse |
| busy_o | output | 1 | Packet in progress |

## Verification
A wrong period count shows at the ports within one period, because the gaps between fire strobes drift away from `PRP_CYCLES`. A chip index or code register that is off by one corrupts the polarity pattern within the first symbol. A wrong symbol counter or handshake decision moves `bit_ready_o` away from a symbol's last cycle, or changes the total length of `busy_o`, and so shows by the first symbol boundary at the latest. Each packet is compared chip by chip, and cycle by cycle, against a sequence built from the code, the preamble count and the bits offered.

// File: rtl/irs_pkg.sv
package irs_pkg;
  localparam int unsigned CODE_LEN = 11;
  localparam logic [CODE_LEN-1:0] CODE_WORD = 11'b11100010010;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irs_prd_timer.sv
module irs_prd_timer #(
  parameter int unsigned PRP_CYCLES = 26
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic prd_start_o,
  output logic prd_end_o
);
  localparam int unsigned CW = (PRP_CYCLES > 2) ? $clog2(PRP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || cnt_q == LAST) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  assign prd_start_o = run_i && (cnt_q == '0);
  assign prd_end_o   = run_i && (cnt_q == LAST);

  // R3: a period start is never followed directly by another one
  a_r3_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prd_start_o |=> !prd_start_o);
endmodule

// File: rtl/irs_chip_gen.sv
module irs_chip_gen
  import irs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  input  logic pol_i,
  output logic chip_o,
  output logic last_o
);
  localparam int unsigned IW = $clog2(CODE_LEN);
  localparam logic [IW-1:0] IDX_LAST = IW'(CODE_LEN - 1);

  logic [CODE_LEN-1:0] rot_q;
  logic [IW-1:0]       idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rot_q <= CODE_WORD;
      idx_q <= '0;
    end else if (clr_i) begin
      rot_q <= CODE_WORD;
      idx_q <= '0;
    end else if (adv_i) begin
      rot_q <= {rot_q[CODE_LEN-2:0], rot_q[CODE_LEN-1]};
      idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
    end
  end

  assign chip_o = rot_q[CODE_LEN-1] ^ pol_i;
  assign last_o = (idx_q == IDX_LAST);

  // R4: the rotating code word is back at its start whenever the index wraps
  a_r4_code_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == '0) |-> (rot_q == CODE_WORD));
endmodule

// File: rtl/irs_frame_ctrl.sv
module irs_frame_ctrl
  import irs_pkg::*;
#(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PRE_W-1:0] pre_len_i,
  input  logic             bit_i,
  input  logic             bit_valid_i,
  input  logic             sym_end_i,
  output logic             bit_ready_o,
  output logic             busy_o,
  output logic             pol_o,
  output logic             clr_o
);
  seq_state_e       state_q, state_d;
  logic [PRE_W-1:0] left_q, left_d;
  logic             pol_q, pol_d;
  logic             pre_last;

  assign pre_last = (state_q == ST_PRE) && (left_q == PRE_W'(1));

  always_comb begin
    bit_ready_o = 1'b0;
    case (state_q)
      ST_IDLE: bit_ready_o = start_i && (pre_len_i == '0);
      ST_PRE:  bit_ready_o = sym_end_i && pre_last;
      ST_DATA: bit_ready_o = sym_end_i;
      default: bit_ready_o = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    left_d  = left_q;
    pol_d   = pol_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        if (pre_len_i != '0) begin
          state_d = ST_PRE;
          left_d  = pre_len_i;
          pol_d   = 1'b0;
        end else if (bit_valid_i) begin
          state_d = ST_DATA;
          pol_d   = bit_i;
        end
      end
      ST_PRE: if (sym_end_i) begin
        if (!pre_last) begin
          left_d = left_q - 1'b1;
        end else if (bit_valid_i) begin
          state_d = ST_DATA;
          pol_d   = bit_i;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_DATA: if (sym_end_i) begin
        if (bit_valid_i) pol_d = bit_i;
        else             state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      pol_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      pol_q   <= pol_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign pol_o  = pol_q;
  assign clr_o  = (state_q == ST_IDLE) && start_i;

  // R8: a packet only ends right after a symbol boundary
  a_r8_end_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(sym_end_i));
  // R9: start while busy away from a boundary leaves the packet running unchanged
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !sym_end_i) |=> (busy_o && $stable(pol_o)));
  // R5: polarity stays unmodulated throughout the preamble
  a_r5_pre_plain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRE) |-> !pol_o);
endmodule

// File: rtl/ir_spread_tx.sv
module ir_spread_tx
  import irs_pkg::*;
#(
  parameter int unsigned PRP_CYCLES = 26,
  parameter int unsigned PRE_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PRE_W-1:0] pre_len_i,
  input  logic             bit_i,
  input  logic             bit_valid_i,
  output logic             bit_ready_o,
  output logic             fire_o,
  output logic             chip_o,
  output logic             busy_o
);
  logic prd_start, prd_end, chip_last, sym_end, pol, clr;

  assign sym_end = prd_end && chip_last;

  irs_frame_ctrl #(.PRE_W(PRE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pre_len_i   (pre_len_i),
    .bit_i       (bit_i),
    .bit_valid_i (bit_valid_i),
    .sym_end_i   (sym_end),
    .bit_ready_o (bit_ready_o),
    .busy_o      (busy_o),
    .pol_o       (pol),
    .clr_o       (clr)
  );

  irs_prd_timer #(.PRP_CYCLES(PRP_CYCLES)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (busy_o),
    .prd_start_o (prd_start),
    .prd_end_o   (prd_end)
  );

  irs_chip_gen u_chip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (prd_end),
    .pol_i  (pol),
    .chip_o (chip_o),
    .last_o (chip_last)
  );

  assign fire_o = prd_start;

  // R3: no pulse outside a packet
  a_r3_fire_in_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> busy_o);
  // R11: polarity only moves on a fire cycle
  a_r11_chip_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fire_o) |-> $stable(chip_o));
  // R7: a taken bit starts a new symbol on the next cycle
  a_r7_take_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_ready_o && bit_valid_i) |=> (busy_o && fire_o));
endmodule

// File: tb/ir_spread_tx_tb.sv
module ir_spread_tx_tb;
  localparam int PRP = 6;
  localparam int SYM = 11 * PRP;
  localparam logic [10:0] CODE = 11'b11100010010;
  // {pre_len, bits offered, bit pattern (bit0 sent first)}
  localparam logic [23:0] VEC [7] = '{
    {8'd2, 8'd3, 8'h05},
    {8'd1, 8'd4, 8'h06},
    {8'd3, 8'd0, 8'h00},
    {8'd0, 8'd2, 8'h03},
    {8'd1, 8'd8, 8'hA5},
    {8'd2, 8'd1, 8'h01},
    {8'd0, 8'd1, 8'h00}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, bit_i = 1'b0, bit_valid_i = 1'b0;
  logic [7:0] pre_len_i = '0;
  logic bit_ready_o, fire_o, chip_o, busy_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ir_spread_tx #(.PRP_CYCLES(PRP), .PRE_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .pre_len_i(pre_len_i),
    .bit_i(bit_i), .bit_valid_i(bit_valid_i), .bit_ready_o(bit_ready_o),
    .fire_o(fire_o), .chip_o(chip_o), .busy_o(busy_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_packet(input int pre, input int avail, input logic [7:0] bits,
                            input bit restart, input string tag);
    logic got [0:255];
    int   stamp [0:255];
    int nf = 0, nbusy = 0, idx = 0, cyc = 0, gap_bad = 0, chip_bad = 0;
    int ready_bad = 0, hold_bad = 0, syms;
    bit take, first_ok;
    logic last_chip = 1'b0;
    @(negedge clk);
    start_i = 1'b1; pre_len_i = 8'(pre);
    bit_valid_i = (avail > 0); bit_i = bits[0];
    #1;
    if (bit_ready_o != (pre == 0)) ready_bad++;
    take = bit_ready_o && bit_valid_i;
    first_ok = 1'b0;
    while (cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (take) idx++;
      start_i = restart && (cyc == 20);
      pre_len_i = restart ? 8'd5 : 8'(pre);
      bit_valid_i = (idx < avail);
      bit_i = bits[idx[2:0]];
      #1;
      if (!busy_o) break;
      nbusy++;
      if (cyc == 1) first_ok = fire_o;
      if (fire_o) begin
        if (nf < 256) begin got[nf] = chip_o; stamp[nf] = cyc; end
        nf++;
        last_chip = chip_o;
      end else if (chip_o != last_chip) hold_bad++;
      if (bit_ready_o != ((cyc % SYM == 0) && (cyc / SYM >= pre))) ready_bad++;
      take = bit_ready_o && bit_valid_i;
    end
    start_i = 1'b0; bit_valid_i = 1'b0;
    syms = pre + avail;
    chk(first_ok, {"R2 first fire with busy ", tag}, int'(first_ok), 1);
    chk(nbusy == syms * SYM, {"R8 busy length ", tag}, nbusy, syms * SYM);
    chk(nf == syms * 11, {"R3 fire count ", tag}, nf, syms * 11);
    for (int i = 0; i < nf && i < 256; i++) begin
      if (stamp[i] != 1 + i * PRP) gap_bad++;
      if (got[i] != (CODE[10 - (i % 11)] ^ ((i / 11) >= pre ? bits[(i / 11) - pre] : 1'b0)))
        chip_bad++;
    end
    chk(gap_bad == 0, {"R3 period spacing ", tag}, gap_bad, 0);
    chk(chip_bad == 0, {"R4 R5 R6 chip sequence ", tag}, chip_bad, 0);
    chk(ready_bad == 0, {"R7 ready timing ", tag}, ready_bad, 0);
    chk(idx == avail, {"R7 bits taken ", tag}, idx, avail);
    chk(hold_bad == 0, {"R11 chip hold ", tag}, hold_bad, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !fire_o && !bit_ready_o, "R1 reset outputs",
        int'({busy_o, fire_o, bit_ready_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !fire_o && !bit_ready_o, "R1 idle after release",
        int'({busy_o, fire_o, bit_ready_o}), 0);

    foreach (VEC[v])
      run_packet(int'(VEC[v][23:16]), int'(VEC[v][15:8]), VEC[v][7:0], 1'b0, $sformatf("vec%0d", v));

    // R9: start pulsed mid-packet with another preamble length
    run_packet(2, 2, 8'h02, 1'b1, "r9_restart");

    // R10: zero preamble and no valid bit -> nothing starts
    @(negedge clk);
    start_i = 1'b1; pre_len_i = 8'd0; bit_valid_i = 1'b0;
    #1;
    chk(bit_ready_o, "R10 ready with zero preamble", int'(bit_ready_o), 1);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(!busy_o && !fire_o, "R10 no packet without bit", int'({busy_o, fire_o}), 0);
    repeat (PRP) @(negedge clk);
    chk(!busy_o, "R10 still idle", int'(busy_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule